// File: doc/BRIEF.md
# Parallel Max-Reward Position Selector

This block picks the board position on which the automated player places its move. Four unsigned reward values, one for each position, arrive together. A two-level tree of compare-and-select nodes works out which position carries the largest reward. Each node passes on the winning reward together with its position index. When rewards are equal, the lower-numbered position wins. Position 0 is the rightmost position on the board.

The index of the winner goes through a decoder that turns it into a one-hot position select. The select and a played strobe are captured into registers on each clock edge at which the game signals the automated player's turn. Between turns the select keeps its last value. The block never passes its turn and never subtracts, so those two flags are held low.

Top module: `max_reward_picker`

## Requirements
- R1: At a rising clock edge with `rst_n` low, `pos_sel` becomes 4'b0000 and `played` becomes 0.
- R2: At a rising edge with `rst_n` high, `clr` low and `turn` high, `pos_sel` takes a value with exactly one bit set. Bit i stands for position i. The bit set is the one for the position with the largest reward, where position i reads `rwd_i[8*i+7:8*i]`.
- R3: When two or more positions share the largest reward, the select from R2 marks the lowest-numbered of them.
- R4: At a rising edge with `rst_n` high, `clr` low and `turn` low, `pos_sel` keeps its previous value.
- R5: After each rising edge with `rst_n` high and `clr` low, `played` equals the value `turn` had at that edge. It is therefore 0 after every edge at which `turn` was low.
- R6: At a rising edge with `rst_n` high and `clr` high, `pos_sel` becomes 4'b0000 and `played` becomes 0, whatever the value of `turn`.
- R7: `skip` and `sub` are 0 at all times.
- R8: `pos_sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of select and played |
| turn | input | 1 | High while the game is in the automated player's turn |
| rwd_i | input | 32 | Four 8-bit unsigned rewards; position i at bits 8*i+7:8*i |
| pos_sel | output | 4 | Registered one-hot select of the chosen position |
| played | output | 1 | Registered strobe; high in the cycle after a turn edge |
| skip | output | 1 | Pass flag, always 0 |
| sub | output | 1 | Subtract flag, always 0 |

## Verification
The assertions assume that the reward bus and the control inputs hold known values at every clock edge once reset is released. The bench meets this by driving every input at time zero and on every falling edge after that. The winner checks compare the tree's output against each reward at every edge, so they expect no unknown bits on `rwd_i`. The random stimulus sometimes draws rewards from a very narrow range so that ties, including ties across all four positions, come up often. Directed cases cover the extreme values 0 and 255.

// File: rtl/max_reward_pkg.sv
// Package: default sizes shared by the selector and its bench.
// Assumes NUM_POS is a power of two (two or more) so the compare tree is balanced.
package max_reward_pkg;
    localparam int unsigned NUM_POS_DEF = 4;
    localparam int unsigned RWD_W_DEF   = 8;
endpackage

// File: rtl/mrp_cmp_node.sv
// One compare-and-select node. It forwards the larger of two (reward, index)
// candidates. Assumes input lo holds lower position numbers than input hi,
// so lo wins on equal rewards.
module mrp_cmp_node #(
    parameter int unsigned RWD_W = 8,
    parameter int unsigned IDX_W = 2
) (
    input  logic [RWD_W-1:0] lo_rwd,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [RWD_W-1:0] hi_rwd,
    input  logic [IDX_W-1:0] hi_idx,
    output logic [RWD_W-1:0] win_rwd,
    output logic [IDX_W-1:0] win_idx
);
    logic take_hi;

    // pick the higher-numbered candidate only on a strict win
    always_comb begin
        take_hi = hi_rwd > lo_rwd;
        win_rwd = take_hi ? hi_rwd : lo_rwd;
        win_idx = take_hi ? hi_idx : lo_idx;
    end
endmodule

// File: rtl/mrp_onehot_dec.sv
// Index to one-hot decoder. Assumes OUT_W <= 2**IDX_W.
module mrp_onehot_dec #(
    parameter int unsigned IDX_W = 2,
    parameter int unsigned OUT_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] onehot
);
    genvar g;
    generate
        for (g = 0; g < OUT_W; g++) begin : g_bit
            // each output bit matches one index value
            assign onehot[g] = (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/max_reward_picker.sv
// Top: picks the position with the largest reward through a balanced tree of
// compare nodes, decodes it and registers the select on turn edges.
// Assumes NUM_POS is a power of two and the rewards are valid at every edge after reset.
module max_reward_picker
    import max_reward_pkg::*;
#(
    parameter int unsigned NUM_POS = NUM_POS_DEF,
    parameter int unsigned RWD_W   = RWD_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       turn,
    input  logic [NUM_POS*RWD_W-1:0]   rwd_i,
    output logic [NUM_POS-1:0]         pos_sel,
    output logic                       played,
    output logic                       skip,
    output logic                       sub
);
    localparam int unsigned IDX_W  = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;
    localparam int unsigned NODE_N = 2 * NUM_POS - 1;
    localparam int unsigned LEAF0  = NUM_POS - 1;

    // heap layout: node n has children 2n+1 (lower positions) and 2n+2
    logic [RWD_W-1:0] t_rwd [NODE_N];
    logic [IDX_W-1:0] t_idx [NODE_N];
    logic [NUM_POS-1:0] dec_sel;

    genvar p, n;
    generate
        for (p = 0; p < NUM_POS; p++) begin : g_leaf
            assign t_rwd[LEAF0+p] = rwd_i[p*RWD_W +: RWD_W];
            assign t_idx[LEAF0+p] = IDX_W'(p);
        end
        for (n = 0; n < NUM_POS - 1; n++) begin : g_node
            mrp_cmp_node #(.RWD_W(RWD_W), .IDX_W(IDX_W)) i_node (
                .lo_rwd (t_rwd[2*n+1]),
                .lo_idx (t_idx[2*n+1]),
                .hi_rwd (t_rwd[2*n+2]),
                .hi_idx (t_idx[2*n+2]),
                .win_rwd(t_rwd[n]),
                .win_idx(t_idx[n])
            );
        end
    endgenerate

    mrp_onehot_dec #(.IDX_W(IDX_W), .OUT_W(NUM_POS)) i_dec (
        .idx   (t_idx[0]),
        .onehot(dec_sel)
    );

    // select register: reset and clear win, otherwise load on a turn edge
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_sel <= '0;
        end else if (turn) begin
            pos_sel <= dec_sel;
        end
    end

    // played strobe follows the turn signal by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            played <= 1'b0;
        end else begin
            played <= turn;
        end
    end

    assign skip = 1'b0;
    assign sub  = 1'b0;

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pos_sel)); // R8
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!turn && !clr) |=> $stable(pos_sel)); // R4
    AST_SEL_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (turn && !clr) |=> $onehot(pos_sel)); // R2
    AST_PLAYED_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (played == $past(turn))); // R5
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pos_sel == '0 && !played)); // R6
    AST_FLAGS_LOW: assert property (@(posedge clk)
        !skip && !sub); // R7

    generate
        for (p = 0; p < NUM_POS; p++) begin : g_chk
            AST_WIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
                t_rwd[0] >= rwd_i[p*RWD_W +: RWD_W]); // R2
            AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (t_rwd[0] == rwd_i[p*RWD_W +: RWD_W]) |-> (t_idx[0] <= IDX_W'(p))); // R3
        end
    endgenerate
endmodule

// File: tb/test_max_reward_picker.sv
module test_max_reward_picker;
    localparam int NP = 4;
    localparam int RW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            turn = 1'b0;
    logic [NP*RW-1:0] rwd_i = '0;
    logic [NP-1:0]   pos_sel;
    logic            played, skip, sub;

    int errors = 0;
    int checks = 0;
    logic [NP-1:0] exp_sel = '0;
    logic          exp_played = 1'b0;

    always #5 clk = ~clk;

    max_reward_picker i_max_reward_picker (
        .clk(clk), .rst_n(rst_n), .clr(clr), .turn(turn), .rwd_i(rwd_i),
        .pos_sel(pos_sel), .played(played), .skip(skip), .sub(sub)
    );

    function automatic logic [NP-1:0] best_sel(logic [NP*RW-1:0] r);
        int b = 0;
        for (int i = 1; i < NP; i++)
            if (r[i*RW +: RW] > r[b*RW +: RW]) b = i;
        return NP'(1) << b;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive on a falling edge, let one rising edge pass, check after it
    task automatic step(logic r, logic c, logic t, logic [NP*RW-1:0] w, string req);
        @(negedge clk);
        rst_n = r; clr = c; turn = t; rwd_i = w;
        @(posedge clk);
        if (!r || c) begin
            exp_sel = '0; exp_played = 1'b0;
        end else begin
            if (t) exp_sel = best_sel(w);
            exp_played = t;
        end
        #1;
        check(req, 32'(pos_sel), 32'(exp_sel));
        check("R5", 32'(played), 32'(exp_played));
        check("R7", {30'd0, skip, sub}, 32'd0);
        check("R8", 32'($countones(pos_sel) <= 1), 32'd1);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(1'b0, 1'b0, 1'b1, 32'h0102_0304, "R1");
        step(1'b0, 1'b0, 1'b0, 32'h0, "R1");
        // directed corners
        step(1'b1, 1'b0, 1'b1, 32'h0000_0000, "R3");      // all zero -> pos 0
        step(1'b1, 1'b0, 1'b1, 32'hFF00_0000, "R2");      // pos 3 max
        step(1'b1, 1'b0, 1'b0, 32'h0000_00FF, "R4");      // hold
        step(1'b1, 1'b0, 1'b1, 32'h7777_7777, "R3");      // all tie -> pos 0
        step(1'b1, 1'b0, 1'b1, 32'h9010_9010, "R3");      // tie 1 and 3 -> pos 1
        step(1'b1, 1'b0, 1'b1, 32'h50A0_A010, "R3");      // tie 1,2 -> pos 1
        step(1'b1, 1'b0, 1'b1, 32'h00FE_00FF, "R2");      // pos 0 max
        step(1'b1, 1'b0, 1'b1, 32'h00FF_00FE, "R2");      // pos 2 max
        step(1'b1, 1'b1, 1'b1, 32'hFF00_0000, "R6");      // clear beats turn
        step(1'b1, 1'b0, 1'b1, 32'h0000_FF00, "R2");
        step(1'b1, 1'b1, 1'b0, 32'h0, "R6");
        step(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, "R3");
        step(1'b0, 1'b0, 1'b1, 32'h0000_FF00, "R1");
        // random mix, some narrow ranges to force ties
        for (int k = 0; k < 600; k++) begin
            logic [NP*RW-1:0] w;
            logic t, c;
            for (int i = 0; i < NP; i++)
                w[i*RW +: RW] = (k % 3 == 0) ? RW'($urandom % 3) : RW'($urandom);
            t = ($urandom % 4) != 0;
            c = ($urandom % 25) == 0;
            step(1'b1, c, t, w, c ? "R6" : (t ? "R2" : "R4"));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule